// File: doc/BRIEF.md
# Receive Frame Checksum Engine

This block sits on the byte-wide receive path of an Ethernet MAC. It computes a 16-bit one's-complement checksum over the payload of each frame as the frame streams past. The result goes to the host, which uses it to check upper-layer protocol checksums without touching every byte again. Each data beat is qualified by a valid flag. Start-of-frame and end-of-frame flags mark the first and last bytes. Because the frame length is not known in advance, the last four bytes (the frame check sequence) are held back in a short delay line. They are never added to the sum.

Two header modes are available, selected by `hdr_mode_i` and captured on the start-of-frame beat. In the basic mode the summed region always begins after the fixed 14-byte MAC header. In the extended mode a small header parser looks at the type/length field. It steps over up to two 802.1Q VLAN tags and over an LLC/SNAP header, so the sum begins at the first byte of the network-layer payload. The checksum appears with a one-cycle strobe in the cycle after the end-of-frame beat. It then stays on the output until the next frame ends.

Top module: `rx_csum_engine`

## Requirements
- R1: While reset is held and after its release, `csum_valid_o` is 0 and `csum_o` is 0x0000 until the first frame ends.
- R2: In basic mode (`hdr_mode_i`=0) the result is the end-around-carry sum of the bytes from index 14 up to index N-5 of an N-byte frame. Bytes are paired as big-endian 16-bit words: the even-index byte is the high byte.
- R3: When the summed region has an odd number of bytes, its last byte is added as a high byte with a zero low byte.
- R4: The final 4 bytes of every frame never enter the sum. A frame of 18 bytes or fewer therefore yields 0x0000.
- R5: `csum_valid_o` is high for exactly one cycle, the cycle after the beat that carries `rx_eof_i`. `csum_o` keeps its value until the next end-of-frame beat.
- R6: A start-of-frame beat clears the running sum. A frame cut short without an end marker has no effect on the next frame's result.
- R7: In extended mode each type field equal to 0x8100 moves the start of the summed region 4 bytes later and moves the next type field 4 bytes later. At most two tags are stepped over; a third 0x8100 is treated as an ordinary type.
- R8: In extended mode, a type field of 1500 (0x05DC) or less followed by bytes 0xAA, 0xAA, 0x03 moves the start 8 bytes further. A value of 0x05DD or more, or any mismatch in those three bytes, causes no move.
- R9: In basic mode, tag or SNAP values in the header have no effect: the start stays at byte 14.
- R10: Cycles with `rx_valid_i` low are ignored, whatever `rx_data_i`, `rx_sof_i` and `rx_eof_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_mode_i | input | 1 | 0: fixed 14-byte header; 1: parse VLAN tags and SNAP (captured at start of frame) |
| rx_valid_i | input | 1 | Data beat qualifier |
| rx_sof_i | input | 1 | First byte of a frame (valid beats only) |
| rx_eof_i | input | 1 | Last byte of a frame (valid beats only) |
| rx_data_i | input | 8 | Received byte |
| csum_o | output | 16 | One's-complement sum of the last completed frame |
| csum_valid_o | output | 1 | One-cycle strobe after the end-of-frame beat |

## Verification
Basic mode is swept over every frame length from 1 to 72 bytes with two byte patterns. This separates the FCS exclusion and the short-frame zero result from the odd/even padding. One pattern runs with idle cycles that carry stray marker values, which tells real beats from ignored ones. Extended mode is run over every tag count from zero to three, crossed with a correct SNAP header, two corrupted ones, a length field just above 1500 and a plain type. Each combination is tried at several lengths, so each header decision shows up as a different start offset. An aborted frame, a one-byte frame and a tagged header fed in basic mode close the set.

// File: rtl/rxcs_pkg.sv
// Package: shared constants, parser states and the end-around-carry adder
// used by the receive checksum engine.
package rxcs_pkg;

    typedef enum logic [1:0] {
        PS_TYPE = 2'd0,   // waiting for a type/length field
        PS_SNAP = 2'd1,   // checking the three LLC bytes
        PS_DONE = 2'd2    // start offset is final
    } parse_st_e;

    // One's-complement addition of two 16-bit words (carry folded back in).
    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

endpackage

// File: rtl/rxcs_fcs_delay.sv
// Module: rxcs_fcs_delay
// Counts byte positions within a frame and holds the newest DEPTH bytes back,
// so a byte is released only once DEPTH later bytes have arrived. The bytes
// still held at end of frame (the FCS) are never released.
// Assumes every frame begins with a valid beat carrying sof.
module rxcs_fcs_delay #(
    parameter int unsigned IDX_W = 12,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_i,
    input  logic             sof_i,
    input  logic [7:0]       data_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             out_vld_o,
    output logic [7:0]       out_byte_o,
    output logic [IDX_W-1:0] out_idx_o
);
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] LAG     = IDX_W'(DEPTH);

    logic [IDX_W-1:0] arr_cnt_q;
    logic [7:0]       line_q [DEPTH];

    // position of the current byte: zero on a start-of-frame beat
    assign idx_o      = sof_i ? '0 : arr_cnt_q;
    assign out_vld_o  = beat_i && (idx_o >= LAG);
    assign out_byte_o = line_q[DEPTH-1];
    assign out_idx_o  = idx_o - LAG;

    // arrival counter, saturating on very long frames
    always_ff @(posedge clk) begin
        if (!rst_n)
            arr_cnt_q <= '0;
        else if (beat_i)
            arr_cnt_q <= (idx_o == IDX_MAX) ? idx_o : idx_o + IDX_W'(1);
    end

    // shift register that holds back the most recent DEPTH bytes
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (!rst_n)
                    line_q[g] <= '0;
                else if (beat_i)
                    line_q[g] <= (g == 0) ? data_i : line_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_i |=> ($stable(arr_cnt_q) && $stable(line_q[DEPTH-1])));

    // R4
    fcs_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i && !sof_i && (arr_cnt_q != IDX_MAX)) |=> (arr_cnt_q == $past(arr_cnt_q) + IDX_W'(1)));

endmodule

// File: rtl/rxcs_hdr_parse.sv
// Module: rxcs_hdr_parse
// Watches arriving header bytes and works out the byte index at which the
// checksum region begins. In basic mode this is always HDR_LEN. In extended
// mode it steps over up to MAX_TAGS VLAN tags and an LLC/SNAP header.
// Assumes the decision is made before the delayed stream reaches the start,
// which holds because every header byte it needs precedes the start by more
// than the delay depth minus the SNAP length.
module rxcs_hdr_parse
    import rxcs_pkg::*;
#(
    parameter int unsigned IDX_W         = 12,
    parameter int unsigned HDR_LEN       = 14,
    parameter int unsigned MAX_TAGS      = 2,
    parameter int unsigned TAG_LEN       = 4,
    parameter int unsigned SNAP_LEN      = 8,
    parameter int unsigned MAX_LEN_FIELD = 1500,
    parameter logic [15:0] TAG_TYPE      = 16'h8100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_i,
    input  logic             sof_i,
    input  logic             mode_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [7:0]       data_i,
    output logic [IDX_W-1:0] start_o
);
    localparam int unsigned      TAGC_W    = $clog2(MAX_TAGS + 1);
    localparam logic [TAGC_W-1:0] TAG_LIMIT = TAGC_W'(MAX_TAGS);
    localparam logic [IDX_W-1:0] TYPE_POS  = IDX_W'(HDR_LEN - 2);
    localparam logic [IDX_W-1:0] BASE      = IDX_W'(HDR_LEN);
    localparam logic [IDX_W-1:0] START_MAX = IDX_W'(HDR_LEN + MAX_TAGS*TAG_LEN + SNAP_LEN);

    parse_st_e         st_q;
    logic [IDX_W-1:0]  typ_pos_q, start_q;
    logic [TAGC_W-1:0] tags_q;
    logic [7:0]        prev_q;
    logic              snap_ok_q, mode_q;
    logic [15:0]       type_w;
    logic              at_type, at_llc0, at_llc1, at_llc2;

    // decode of the current byte position relative to the type field
    always_comb begin
        type_w  = {prev_q, data_i};
        at_type = idx_i == typ_pos_q + IDX_W'(1);
        at_llc0 = idx_i == typ_pos_q + IDX_W'(2);
        at_llc1 = idx_i == typ_pos_q + IDX_W'(3);
        at_llc2 = idx_i == typ_pos_q + IDX_W'(4);
    end

    assign start_o = start_q;

    // header walk: tags, then length field and LLC/SNAP bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PS_TYPE; typ_pos_q <= TYPE_POS; start_q <= BASE;
            tags_q <= '0; prev_q <= '0; snap_ok_q <= 1'b0; mode_q <= 1'b0;
        end else if (beat_i) begin
            prev_q <= data_i;
            if (sof_i) begin
                st_q <= PS_TYPE; typ_pos_q <= TYPE_POS; start_q <= BASE;
                tags_q <= '0; snap_ok_q <= 1'b0; mode_q <= mode_i;
            end else begin
                case (st_q)
                    PS_TYPE: if (at_type) begin
                        if (!mode_q) begin
                            st_q <= PS_DONE;
                        end else if (type_w == TAG_TYPE && tags_q < TAG_LIMIT) begin
                            typ_pos_q <= typ_pos_q + IDX_W'(TAG_LEN);
                            start_q   <= start_q + IDX_W'(TAG_LEN);
                            tags_q    <= tags_q + TAGC_W'(1);
                        end else if (type_w <= 16'(MAX_LEN_FIELD)) begin
                            st_q <= PS_SNAP;
                        end else begin
                            st_q <= PS_DONE;
                        end
                    end
                    PS_SNAP: begin
                        if (at_llc0) snap_ok_q <= (data_i == 8'hAA);
                        if (at_llc1) snap_ok_q <= snap_ok_q && (data_i == 8'hAA);
                        if (at_llc2) begin
                            if (snap_ok_q && data_i == 8'h03)
                                start_q <= start_q + IDX_W'(SNAP_LEN);
                            st_q <= PS_DONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9
    basic_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (start_q == BASE));

    // R7
    tag_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tags_q <= TAG_LIMIT);

    // R8
    start_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q >= BASE) && (start_q <= START_MAX));

    // R7
    start_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i && !sof_i) |=> (start_q >= $past(start_q)));

endmodule

// File: rtl/rxcs_accum.sv
// Module: rxcs_accum
// Adds released bytes at or beyond the start index into a one's-complement
// sum as big-endian word halves, then latches the sum and raises a strobe
// on the end-of-frame beat. Assumes the start index is even.
module rxcs_accum
    import rxcs_pkg::*;
#(
    parameter int unsigned IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_i,
    input  logic             sof_i,
    input  logic             eof_i,
    input  logic             byte_vld_i,
    input  logic [7:0]       byte_i,
    input  logic [IDX_W-1:0] byte_idx_i,
    input  logic [IDX_W-1:0] start_i,
    output logic [15:0]      csum_o,
    output logic             csum_valid_o
);
    logic [15:0] acc_q, acc_next, word;
    logic        sum_en;

    // next running sum: cleared at start of frame, else add the released byte
    always_comb begin
        word     = byte_idx_i[0] ? {8'h00, byte_i} : {byte_i, 8'h00};
        sum_en   = byte_vld_i && (byte_idx_i >= start_i);
        acc_next = sof_i ? 16'h0000 : (sum_en ? oc_add(acc_q, word) : acc_q);
    end

    // running sum, result register and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0; csum_o <= '0; csum_valid_o <= 1'b0;
        end else begin
            csum_valid_o <= beat_i && eof_i;
            if (beat_i) acc_q <= acc_next;
            if (beat_i && eof_i) csum_o <= acc_next;
        end
    end

    // R5
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csum_valid_o |-> $past(beat_i && eof_i));

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_i && eof_i) |=> $stable(csum_o));

    // R6
    sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i && sof_i) |=> (acc_q == 16'h0000));

endmodule

// File: rtl/rx_csum_engine.sv
// Module: rx_csum_engine (top)
// Receive frame checksum engine: FCS delay line, header parser and
// one's-complement accumulator. Assumes sof/eof are meaningful only on
// valid beats, that each frame opens with sof, and that the mode input is
// steady around the start-of-frame beat.
module rx_csum_engine #(
    parameter int unsigned IDX_W    = 12,
    parameter int unsigned FCS_LEN  = 4,
    parameter int unsigned HDR_LEN  = 14,
    parameter int unsigned MAX_TAGS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hdr_mode_i,
    input  logic        rx_valid_i,
    input  logic        rx_sof_i,
    input  logic        rx_eof_i,
    input  logic [7:0]  rx_data_i,
    output logic [15:0] csum_o,
    output logic        csum_valid_o
);
    logic [IDX_W-1:0] idx, rel_idx, start;
    logic             rel_vld;
    logic [7:0]       rel_byte;

    rxcs_fcs_delay #(.IDX_W(IDX_W), .DEPTH(FCS_LEN)) u_dly (
        .clk(clk), .rst_n(rst_n), .beat_i(rx_valid_i), .sof_i(rx_sof_i),
        .data_i(rx_data_i), .idx_o(idx), .out_vld_o(rel_vld),
        .out_byte_o(rel_byte), .out_idx_o(rel_idx)
    );

    rxcs_hdr_parse #(.IDX_W(IDX_W), .HDR_LEN(HDR_LEN), .MAX_TAGS(MAX_TAGS)) u_hdr (
        .clk(clk), .rst_n(rst_n), .beat_i(rx_valid_i), .sof_i(rx_sof_i),
        .mode_i(hdr_mode_i), .idx_i(idx), .data_i(rx_data_i), .start_o(start)
    );

    rxcs_accum #(.IDX_W(IDX_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .beat_i(rx_valid_i), .sof_i(rx_sof_i),
        .eof_i(rx_eof_i), .byte_vld_i(rel_vld), .byte_i(rel_byte),
        .byte_idx_i(rel_idx), .start_i(start), .csum_o(csum_o),
        .csum_valid_o(csum_valid_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!csum_valid_o && csum_o == 16'h0000));

endmodule

// File: tb/sim_rx_csum_engine.sv
module sim_rx_csum_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_mode_i = 1'b0;
    logic        rx_valid_i = 1'b0;
    logic        rx_sof_i = 1'b0;
    logic        rx_eof_i = 1'b0;
    logic [7:0]  rx_data_i = 8'h00;
    logic [15:0] csum_o;
    logic        csum_valid_o;

    int checks = 0;
    int errs = 0;
    logic [7:0] frm [0:127];

    rx_csum_engine u0 (
        .clk(clk), .rst_n(rst_n), .hdr_mode_i(hdr_mode_i), .rx_valid_i(rx_valid_i),
        .rx_sof_i(rx_sof_i), .rx_eof_i(rx_eof_i), .rx_data_i(rx_data_i),
        .csum_o(csum_o), .csum_valid_o(csum_valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected sum from the requirements: start offset, FCS cut, word pairing.
    function automatic logic [15:0] model(input int len, input bit m);
        int st = 14;
        int t = 12;
        int ntag = 0;
        logic [16:0] s;
        logic [15:0] acc = 16'h0000;
        logic [15:0] w;
        if (m) begin
            while (ntag < 2 && t + 1 < len && {frm[t], frm[t+1]} == 16'h8100) begin
                t += 4; st += 4; ntag++;
            end
            if (t + 4 < len && {frm[t], frm[t+1]} <= 16'd1500 &&
                frm[t+2] == 8'hAA && frm[t+3] == 8'hAA && frm[t+4] == 8'h03)
                st += 8;
        end
        for (int i = st; i < len - 4; i += 2) begin
            w = {frm[i], (i + 1 < len - 4) ? frm[i+1] : 8'h00};
            s = {1'b0, acc} + {1'b0, w};
            acc = s[15:0] + {15'd0, s[16]};
        end
        return acc;
    endfunction

    task automatic fill(input int len, input int seed);
        for (int i = 0; i < len; i++) frm[i] = 8'((i * 37 + seed * 11 + 3) & 255);
    endtask

    // kind: 0 plain type, 1 good SNAP, 2 bad 2nd AA, 3 bad 03, 4 length 1501
    task automatic hdr(input int ntag, input int kind);
        int p = 12;
        for (int k = 0; k < ntag; k++) begin
            frm[p] = 8'h81; frm[p+1] = 8'h00; p += 4;
        end
        if (kind == 0) begin
            frm[p] = 8'h08; frm[p+1] = 8'h00;
        end else begin
            frm[p] = 8'h05; frm[p+1] = (kind == 4) ? 8'hDD : 8'hDC;
            frm[p+2] = 8'hAA;
            frm[p+3] = (kind == 2) ? 8'hAB : 8'hAA;
            frm[p+4] = (kind == 3) ? 8'h04 : 8'h03;
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        chk(csum_valid_o == 1'b0, "R5 idle", int'(csum_valid_o), 0);
        rx_valid_i = 1'b0; rx_sof_i = 1'b1; rx_eof_i = 1'b1; rx_data_i = 8'h5A; // R10 stray markers
    endtask

    task automatic send_frame(input int len, input bit m, input bit gaps, input int seed,
                              input bit close, input string req);
        logic [15:0] exp_v;
        logic [15:0] held;
        exp_v = model(len, m);
        for (int i = 0; i < len; i++) begin
            if (gaps && ((i * 7 + seed) % 3 == 0)) idle_cycle();
            @(negedge clk);
            chk(csum_valid_o == 1'b0, "R5 no strobe mid-frame", int'(csum_valid_o), 0);
            hdr_mode_i = m;
            rx_valid_i = 1'b1; rx_data_i = frm[i];
            rx_sof_i = (i == 0); rx_eof_i = close && (i == len - 1);
        end
        @(negedge clk);
        rx_valid_i = 1'b0; rx_sof_i = 1'b0; rx_eof_i = 1'b0;
        if (close) begin
            chk(csum_valid_o == 1'b1, "R5 strobe after eof", int'(csum_valid_o), 1);
            chk(csum_o == exp_v, req, int'(csum_o), int'(exp_v));
            held = csum_o;
            @(negedge clk);
            chk(csum_valid_o == 1'b0, "R5 single-cycle strobe", int'(csum_valid_o), 0);
            chk(csum_o == held, "R5 result held", int'(csum_o), int'(held));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(csum_valid_o == 1'b0, "R1 strobe in reset", int'(csum_valid_o), 0);
        chk(csum_o == 16'h0000, "R1 sum in reset", int'(csum_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(csum_valid_o == 1'b0, "R1 strobe after reset", int'(csum_valid_o), 0);
        chk(csum_o == 16'h0000, "R1 sum after reset", int'(csum_o), 0);

        // R2 R3 R4 R10: basic mode length sweep, two patterns, gaps on the second
        for (int len = 1; len <= 72; len++) begin
            fill(len, len);
            send_frame(len, 1'b0, 1'b0, len, 1'b1, "R2 R3 R4 basic sweep");
            fill(len, len + 50);
            send_frame(len, 1'b0, 1'b1, len, 1'b1, "R10 R2 basic sweep with gaps");
        end

        // R9: tag and SNAP bytes in basic mode
        fill(60, 7); hdr(2, 1);
        send_frame(60, 1'b0, 1'b0, 0, 1'b1, "R9 basic mode ignores tags");
        fill(48, 9); hdr(0, 1);
        send_frame(48, 1'b0, 1'b0, 0, 1'b1, "R9 basic mode ignores SNAP");

        // R7 R8: extended mode header combinations
        for (int nt = 0; nt <= 3; nt++)
            for (int kind = 0; kind <= 4; kind++)
                for (int len = 20; len <= 70; len += 5) begin
                    fill(len, nt * 5 + kind);
                    hdr(nt, kind);
                    send_frame(len, 1'b1, (len % 10) == 0, kind, 1'b1,
                               (kind == 0) ? "R7 tag skip" : "R8 SNAP skip");
                end

        // R6: aborted frame then a full one
        fill(30, 3);
        send_frame(30, 1'b1, 1'b0, 0, 1'b0, "R6 abort");
        fill(40, 4); hdr(1, 1);
        send_frame(40, 1'b1, 1'b0, 0, 1'b1, "R6 sum cleared at sof");

        // R4: single-byte frame
        fill(1, 8);
        send_frame(1, 1'b0, 1'b0, 0, 1'b1, "R4 one-byte frame");

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule